// File: doc/BRIEF.md
# Bus Slave Burst Terminate Generator

This block sits inside a bus slave. For each read or write burst it decides the one cycle in which the slave raises its burst-terminate strobe. It follows the transfer from the address acknowledge, or from the event that promotes a queued request to primary, up to the completion signal of that direction. It counts either clock cycles or the slave's own data acknowledges. The read path and the write path are separate, so one read burst and one write burst can be followed at the same time.

Configuration arrives on plain pins: a terminate enable, a counting base and a count value. A fixed-length mode takes the burst length from the request byte enables instead of from the count. That length is the byte-enable value plus one transfers. Terminate then lands with the second-to-last data acknowledge. The byte enables and the transfer size are captured at address acknowledge. Configuration is expected to stay stable while a burst is in flight. Every output is a single-cycle strobe. It is gated by the window in which the protocol allows a terminate: for reads, from the cycle after the start event; for writes, from the address-acknowledge cycle itself, or from the cycle after a write-primary event.

Top module: `burst_term_gen`

## Requirements
- R1: After reset, and while no burst has started, both terminate outputs are low.
- R2: With the terminate enable set, the clock base selected (cfg_cnt_mode=0) and count N, the read strobe rises in the Nth cycle after the address-acknowledge cycle, which is cycle 0. It is high for that one cycle only.
- R3: With the acknowledge base selected (cfg_cnt_mode=1) and count N, the strobe rises in the cycle that carries the Nth data acknowledge since the start of the burst, counting that cycle's own acknowledge.
- R4: When fixed-length mode is on, the captured byte enables are non-zero and the top bit of the captured size is 1 (burst), the strobe rises in the cycle carrying the data acknowledge whose number equals the byte-enable value. That is the second-to-last of value+1 transfers. This rule overrides the count settings.
- R5: When fixed-length mode is on but the request does not qualify (byte enables zero or size top bit 0), the count settings apply unchanged.
- R6: The read strobe is never high in the read address-acknowledge cycle or in a read-primary cycle. With the clock base and count 0 it rises in the cycle after either event.
- R7: The write strobe may rise in the write address-acknowledge cycle: with the clock base and count 0 it does so. After a write-primary event it rises no earlier than the next cycle.
- R8: The complete cycle is the last cycle in which a strobe may occur. After it the strobe stays low until a new start, even if the count has not yet been reached.
- R9: A strobe is at most one cycle long and occurs at most once per burst.
- R10: A new address acknowledge of the same direction during a burst restarts the counting from zero.
- R11: Read and write bursts are tracked independently and may overlap.
- R12: With the terminate enable and fixed-length mode both off, neither strobe ever rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_term_en | input | 1 | Enable count-based terminate |
| cfg_cnt_mode | input | 1 | 0 = count clocks, 1 = count data acknowledges |
| cfg_count | input | CNT_W | Count value |
| cfg_fixed_en | input | 1 | Enable fixed-length burst terminate |
| addr_ack | input | 1 | Slave address acknowledge |
| req_rnw | input | 1 | Request direction at address acknowledge, 1 = read |
| req_be | input | BE_W | Request byte enables, captured at address acknowledge |
| req_size | input | SZ_W | Request size; top bit 1 marks a burst |
| rd_prim | input | 1 | Queued read request becomes primary |
| wr_prim | input | 1 | Queued write request becomes primary |
| rd_dack | input | 1 | Slave read data acknowledge |
| wr_dack | input | 1 | Slave write data acknowledge |
| rd_comp | input | 1 | Read transfer complete |
| wr_comp | input | 1 | Write transfer complete |
| rd_bterm | output | 1 | Read burst-terminate strobe |
| wr_bterm | output | 1 | Write burst-terminate strobe |

## Verification
The strobes are combinational from the current cycle's event inputs and from registered counts. A result is therefore due in the same cycle as the acknowledge, or the Nth clock after the start, that triggers it. In clock mode that cycle is counted with the address-acknowledge cycle as cycle 0. The bench drives every input at the falling edge and samples both strobes 3 ns later, before the next rising edge. Each cycle compares both outputs against an expected value worked out from the requirements, so early, late or repeated strobes on either path are all seen.

// File: rtl/btg_pkg.sv
package btg_pkg;
  typedef enum logic {
    CNT_CLOCKS = 1'b0,
    CNT_ACKS   = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/btg_counter.sv
module btg_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= '0;
    else if (load)              q <= load_val;
    else if (inc && q != MAXV)  q <= q + 1'b1;
  end

  // R2
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> q >= $past(q));
endmodule

// File: rtl/btg_window.sv
module btg_window #(
  parameter bit IS_WRITE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic aa_start,
  input  logic prim_start,
  input  logic comp,
  output logic start,
  output logic active,
  output logic open
);
  assign start = aa_start | prim_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active <= 1'b0;
    else if (start) active <= 1'b1;
    else if (comp)  active <= 1'b0;
  end

  generate
    if (IS_WRITE) begin : g_wr
      assign open = (active & ~prim_start) | aa_start;
    end else begin : g_rd
      assign open = active & ~start;
    end
  endgenerate
endmodule

// File: rtl/btg_path.sv
module btg_path
  import btg_pkg::*;
#(
  parameter bit IS_WRITE = 1'b0,
  parameter int CNT_W    = 8,
  parameter int BE_W     = 4,
  parameter int SZ_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aa_start,
  input  logic             prim_start,
  input  logic             dack,
  input  logic             comp,
  input  logic [BE_W-1:0]  req_be,
  input  logic [SZ_W-1:0]  req_size,
  input  logic             cfg_term_en,
  input  cnt_mode_e        cfg_cnt_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_fixed_en,
  output logic             bterm
);
  localparam int SW = CNT_W + 1;

  logic             start, active, open;
  logic [CNT_W-1:0] cyc_q, ack_q, ack_ld;
  logic [BE_W-1:0]  be_q, be_e;
  logic [SZ_W-1:0]  size_q, size_e;
  logic [CNT_W-1:0] k_now, ack_base;
  logic [SW-1:0]    ack_incl, be_ext;
  logic             qual, cond, fired, fire;

  btg_window #(.IS_WRITE(IS_WRITE)) u_win (
    .clk(clk), .rst_n(rst_n), .aa_start(aa_start), .prim_start(prim_start),
    .comp(comp), .start(start), .active(active), .open(open)
  );

  btg_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .load(start | comp),
    .load_val(start ? CNT_W'(1) : '0), .inc(active), .q(cyc_q)
  );

  assign ack_ld = (start && dack) ? CNT_W'(1) : '0;

  btg_counter #(.W(CNT_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .load(start | comp),
    .load_val(ack_ld), .inc(active & dack), .q(ack_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q   <= '0;
      size_q <= '0;
    end else if (aa_start) begin
      be_q   <= req_be;
      size_q <= req_size;
    end
  end

  assign be_e     = aa_start ? req_be   : be_q;
  assign size_e   = aa_start ? req_size : size_q;
  assign k_now    = start ? '0 : cyc_q;
  assign ack_base = start ? '0 : ack_q;
  assign ack_incl = {1'b0, ack_base} + SW'(dack);
  assign be_ext   = SW'(be_e);
  assign qual     = cfg_fixed_en && (be_e != '0) && size_e[SZ_W-1];

  always_comb begin
    if (qual)
      cond = (ack_incl >= be_ext);
    else if (cfg_term_en)
      cond = (cfg_cnt_mode == CNT_CLOCKS) ? (k_now >= cfg_count)
                                          : (ack_incl >= {1'b0, cfg_count});
    else
      cond = 1'b0;
  end

  assign fire  = open & cond & ~(fired & ~start);
  assign bterm = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fired <= 1'b0;
    else if (start) fired <= fire;
    else if (comp)  fired <= 1'b0;
    else if (fire)  fired <= 1'b1;
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bterm |=> (!bterm || aa_start || prim_start));

  // R8
  post_comp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp && !aa_start && !prim_start) |=> (!bterm || aa_start || prim_start));
endmodule

// File: rtl/burst_term_gen.sv
module burst_term_gen
  import btg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BE_W  = 4,
  parameter int SZ_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_term_en,
  input  logic             cfg_cnt_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_fixed_en,
  input  logic             addr_ack,
  input  logic             req_rnw,
  input  logic [BE_W-1:0]  req_be,
  input  logic [SZ_W-1:0]  req_size,
  input  logic             rd_prim,
  input  logic             wr_prim,
  input  logic             rd_dack,
  input  logic             wr_dack,
  input  logic             rd_comp,
  input  logic             wr_comp,
  output logic             rd_bterm,
  output logic             wr_bterm
);
  localparam int NPATH = 2;

  logic [NPATH-1:0] p_aa, p_prim, p_dack, p_comp, p_bterm;
  cnt_mode_e        mode;

  assign mode   = cnt_mode_e'(cfg_cnt_mode);
  assign p_aa   = {addr_ack & ~req_rnw, addr_ack & req_rnw};
  assign p_prim = {wr_prim, rd_prim};
  assign p_dack = {wr_dack, rd_dack};
  assign p_comp = {wr_comp, rd_comp};

  generate
    for (genvar g = 0; g < NPATH; g++) begin : g_path
      btg_path #(
        .IS_WRITE(g == 1), .CNT_W(CNT_W), .BE_W(BE_W), .SZ_W(SZ_W)
      ) u_path (
        .clk(clk), .rst_n(rst_n),
        .aa_start(p_aa[g]), .prim_start(p_prim[g]),
        .dack(p_dack[g]), .comp(p_comp[g]),
        .req_be(req_be), .req_size(req_size),
        .cfg_term_en(cfg_term_en), .cfg_cnt_mode(mode),
        .cfg_count(cfg_count), .cfg_fixed_en(cfg_fixed_en),
        .bterm(p_bterm[g])
      );
    end
  endgenerate

  assign rd_bterm = p_bterm[0];
  assign wr_bterm = p_bterm[1];

  // R6
  rd_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_ack && req_rnw) || rd_prim) |-> !rd_bterm);

  // R7
  wr_prim_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_prim && !(addr_ack && !req_rnw)) |-> !wr_bterm);

  // R12
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_term_en && !cfg_fixed_en) |-> (!rd_bterm && !wr_bterm));
endmodule

// File: tb/sim_burst_term_gen.sv
module sim_burst_term_gen;
  localparam int AA = 1, RNW = 2, RDK = 4, WDK = 8, RCP = 16, WCP = 32, RPR = 64, WPR = 128;

  logic       clk = 0, rst_n = 0;
  logic       term_en = 0, cnt_mode = 0, fixed_en = 0;
  logic [7:0] count = 0;
  logic       addr_ack = 0, rnw = 0, rd_prim = 0, wr_prim = 0;
  logic       rd_dack = 0, wr_dack = 0, rd_comp = 0, wr_comp = 0;
  logic [3:0] be = 0, size = 0;
  logic       rb, wb;
  int runs = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_term_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_term_en(term_en), .cfg_cnt_mode(cnt_mode),
    .cfg_count(count), .cfg_fixed_en(fixed_en), .addr_ack(addr_ack), .req_rnw(rnw),
    .req_be(be), .req_size(size), .rd_prim(rd_prim), .wr_prim(wr_prim),
    .rd_dack(rd_dack), .wr_dack(wr_dack), .rd_comp(rd_comp), .wr_comp(wr_comp),
    .rd_bterm(rb), .wr_bterm(wb)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic step(input int c, input logic erb, input logic ewb, input string tag);
    @(negedge clk);
    addr_ack = c[0]; rnw = c[1]; rd_dack = c[2]; wr_dack = c[3];
    rd_comp = c[4]; wr_comp = c[5]; rd_prim = c[6]; wr_prim = c[7];
    #3;
    chk({tag, " rd"}, rb, erb);
    chk({tag, " wr"}, wb, ewb);
  endtask

  task automatic setcfg(input logic te, input logic md, input int n, input logic fx,
                        input int b, input int s);
    term_en = te; cnt_mode = md; count = 8'(n); fixed_en = fx; be = 4'(b); size = 4'(s);
  endtask

  task automatic t_reset;
    chk("R1 in reset rd", rb, 1'b0);
    chk("R1 in reset wr", wb, 1'b0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R1 idle");
  endtask

  task automatic t_clk_read;
    setcfg(1, 0, 3, 0, 0, 0);
    step(AA|RNW, 0, 0, "R2 c0");
    step(0, 0, 0, "R2 c1");
    step(0, 0, 0, "R2 c2");
    step(0, 1, 0, "R2 c3");
    step(0, 0, 0, "R9 c4");
    step(RCP, 0, 0, "R9 comp");
    step(0, 0, 0, "R2 idle");
  endtask

  task automatic t_ack_read;
    setcfg(1, 1, 2, 0, 0, 0);
    step(AA|RNW, 0, 0, "R3 c0");
    step(RDK, 0, 0, "R3 ack1");
    step(0, 0, 0, "R3 gap");
    step(RDK, 1, 0, "R3 ack2");
    step(RDK, 0, 0, "R9 ack3");
    step(RDK|RCP, 0, 0, "R3 comp");
    step(0, 0, 0, "R3 idle");
  endtask

  task automatic t_fixed;
    setcfg(1, 0, 1, 1, 3, 8);
    step(AA|RNW, 0, 0, "R4 c0");
    step(RDK, 0, 0, "R4 ack1 override");
    step(RDK, 0, 0, "R4 ack2");
    step(RDK, 1, 0, "R4 ack3");
    step(RDK|RCP, 0, 0, "R4 ack4");
    step(0, 0, 0, "R4 idle");
    setcfg(0, 0, 0, 1, 1, 8);
    step(AA|WDK, 0, 1, "R4 wr ack1 at aa");
    step(WDK|WCP, 0, 0, "R4 wr ack2");
    step(0, 0, 0, "R4 wr idle");
  endtask

  task automatic t_fixed_unqual;
    setcfg(0, 0, 0, 1, 3, 2);
    step(AA|RNW, 0, 0, "R5 nb c0");
    for (int i = 0; i < 3; i++) step(RDK, 0, 0, "R5 nb ack");
    step(RDK|RCP, 0, 0, "R5 nb comp");
    setcfg(1, 0, 1, 1, 0, 8);
    step(AA|RNW, 0, 0, "R5 be0 c0");
    step(0, 1, 0, "R5 be0 c1");
    step(RCP, 0, 0, "R5 be0 comp");
    setcfg(0, 0, 0, 0, 3, 8);
    step(AA|RNW, 0, 0, "R12 c0");
    for (int i = 0; i < 3; i++) step(RDK, 0, 0, "R12 ack");
    step(RDK|RCP, 0, 0, "R12 comp");
    step(0, 0, 0, "R12 idle");
  endtask

  task automatic t_windows;
    setcfg(1, 0, 0, 0, 0, 0);
    step(AA|RNW, 0, 0, "R6 aa");
    step(0, 1, 0, "R6 aa+1");
    step(RCP, 0, 0, "R6 comp");
    step(RPR, 0, 0, "R6 prim");
    step(0, 1, 0, "R6 prim+1");
    step(RCP, 0, 0, "R6 prim comp");
    step(AA, 0, 1, "R7 aa");
    step(0, 0, 0, "R7 aa+1");
    step(WCP, 0, 0, "R7 comp");
    step(WPR, 0, 0, "R7 prim");
    step(0, 0, 1, "R7 prim+1");
    step(WCP, 0, 0, "R7 prim comp");
    step(0, 0, 0, "R7 idle");
  endtask

  task automatic t_comp_early;
    setcfg(1, 0, 5, 0, 0, 0);
    step(AA|RNW, 0, 0, "R8 c0");
    step(0, 0, 0, "R8 c1");
    step(0, 0, 0, "R8 c2");
    step(RCP, 0, 0, "R8 comp");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R8 after");
  endtask

  task automatic t_restart;
    setcfg(1, 0, 3, 0, 0, 0);
    step(AA|RNW, 0, 0, "R10 c0");
    step(0, 0, 0, "R10 c1");
    step(AA|RNW, 0, 0, "R10 restart");
    step(0, 0, 0, "R10 k1");
    step(0, 0, 0, "R10 k2");
    step(0, 1, 0, "R10 k3");
    step(RCP, 0, 0, "R10 comp");
  endtask

  task automatic t_overlap;
    setcfg(1, 0, 2, 0, 0, 0);
    step(AA|RNW, 0, 0, "R11 rd aa");
    step(AA, 0, 0, "R11 wr aa");
    step(0, 1, 0, "R11 rd fire");
    step(0, 0, 1, "R11 wr fire");
    step(RCP, 0, 0, "R11 rd comp");
    step(WCP, 0, 0, "R11 wr comp");
    step(0, 0, 0, "R11 idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_clk_read();
    t_ack_read();
    t_fixed();
    t_fixed_unqual();
    t_windows();
    t_comp_early();
    t_restart();
    t_overlap();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      runs++; fails++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule